// File: doc/BRIEF.md
# Measurement Conversion Sequencer

This block schedules the conversions of a three-channel power monitor. The channels are bus voltage, shunt current and die temperature. A 4-bit mode field selects one of three behaviours. In shutdown nothing runs. In triggered single-shot operation, one strobe starts one pass over a chosen set of channels. In continuous operation the passes repeat for as long as the mode stays continuous.

For each channel the block holds a conversion request high for a window. The window length is set by a 3-bit time code and is counted in microsecond ticks. At the last tick of the window it takes the value on a shared sample bus. A current conversion lasts as long as the shunt time plus the temperature time.

Samples are summed per channel over a selectable number of passes. Once the last pass ends, the averaged results are published together with a one-cycle completion pulse. An optional start delay can be placed before the first window of a run; it is a multiple of a fixed tick step.

The converter itself sits outside the block. It sees the request lines and drives the sample bus. Configuration fields are sampled when a run starts and again at every continuous restart.

Top module: `conv_seq`

## Requirements
- R1: Mode codes 0h, 8h, 2h, 3h, Ah and Bh mean shutdown. In these modes no request is raised, no completion pulse appears, and a trigger strobe is ignored.
- R2: The single-shot codes select these channel sets, and each run starts on one trigger strobe taken while idle:
  - 1h: bus.
  - 4h: temperature.
  - 5h: temperature and bus.
  - 6h: temperature and current.
  - 7h: all three.

  A run performs one full averaging set, gives exactly one completion pulse, and then stays idle until the next strobe.
- R3: The continuous codes 9h, Ch, Dh, Eh and Fh use the same channel sets as 1h, 4h, 5h, 6h and 7h. Such a run starts without a trigger. After each completion pulse it restarts at once, with no start delay, for as long as the mode stays continuous. A trigger strobe has no effect on its timing.
- R4: Requests use bit 0 for bus, bit 1 for current and bit 2 for temperature. At most one request bit is high at a time. Within a pass the order is bus, then current, then temperature, and unselected channels are skipped.
- R5: A window lasts a number of ticks set by a time code:

  | Code | Ticks |
  |---|---|
  | 0 | 50 |
  | 1 | 84 |
  | 2 | 150 |
  | 3 | 280 |
  | 4 | 540 |
  | 5 | 1052 |
  | 6 | 2074 |
  | 7 | 4120 |

  The bus window uses the bus code and the temperature window uses the temperature code. The current window lasts shunt code plus temperature code. A request line changes only on a cycle with a tick, or when the mode turns to shutdown. The sample is taken on the last tick cycle of the window.
- R6: The averaging code 0 to 7 selects 1, 4, 16, 64, 128, 256, 512 or 1024 passes. Each selected result equals the sum of its samples, treated as signed, arithmetically shifted right by log2 of the count, and truncated to the result width.
- R7: When a run starts from idle, the first request rises a fixed number of cycles after the starting cycle. That number is start-delay field × step ticks + 1, where the step is a parameter. Every cycle of the delay carries a tick.
- R8: While reset is held, all requests, the completion pulse and all results are zero.
- R9: If the mode turns to a shutdown code during a run, requests drop on the next cycle, no completion pulse follows, and the results keep their values.
- R10: The completion pulse lasts one cycle. Results change only in the cycle where that pulse is high, and only for the channels of the finished run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 4 | Operating mode and channel set |
| cfg_bus_ct | input | 3 | Bus window time code |
| cfg_shunt_ct | input | 3 | Shunt window time code |
| cfg_temp_ct | input | 3 | Temperature window time code |
| cfg_avg | input | 3 | Averaging count code |
| cfg_start_dly | input | DLY_CODE_W | Start delay in steps |
| trig | input | 1 | Single-shot start strobe |
| us_tick | input | 1 | Microsecond time base pulse |
| sample_in | input | DATA_W | Converter sample bus |
| conv_req | output | 3 | Per-channel conversion request |
| res_bus | output | DATA_W | Averaged bus result |
| res_cur | output | DATA_W | Averaged current result |
| res_tmp | output | DATA_W | Averaged temperature result |
| done | output | 1 | Completion pulse |

## Verification
The bench builds the block with DATA_W of 16 and a delay step of 20 ticks instead of 2000. This brings all non-zero start delays within a short run. Ticks arrive on every clock for most runs, so short time codes and averaging counts of 1, 4 and 16 complete within the cycle budget. One run thins the ticks to every third cycle, which exercises window stretching and request holding between ticks. Random signed samples exercise negative sums and the arithmetic shift.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  localparam int NCH       = 3;
  localparam int CT_W      = 14;
  localparam int AVG_LOG_W = 10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;

  // window length in ticks for a 3-bit time code
  function automatic logic [CT_W-1:0] ct_ticks(input logic [2:0] code);
    case (code)
      3'd0:    ct_ticks = CT_W'(50);
      3'd1:    ct_ticks = CT_W'(84);
      3'd2:    ct_ticks = CT_W'(150);
      3'd3:    ct_ticks = CT_W'(280);
      3'd4:    ct_ticks = CT_W'(540);
      3'd5:    ct_ticks = CT_W'(1052);
      3'd6:    ct_ticks = CT_W'(2074);
      default: ct_ticks = CT_W'(4120);
    endcase
  endfunction

  // log2 of the pass count
  function automatic logic [3:0] avg_log(input logic [2:0] code);
    case (code)
      3'd0:    avg_log = 4'd0;
      3'd1:    avg_log = 4'd2;
      3'd2:    avg_log = 4'd4;
      3'd3:    avg_log = 4'd6;
      3'd4:    avg_log = 4'd7;
      3'd5:    avg_log = 4'd8;
      3'd6:    avg_log = 4'd9;
      default: avg_log = 4'd10;
    endcase
  endfunction

  // channel set: bit0 bus, bit1 current, bit2 temperature; zero = off
  function automatic logic [2:0] chan_set(input logic [3:0] mode);
    if (mode[1] && !mode[2]) chan_set = 3'b000;
    else                     chan_set = {mode[2], mode[1], mode[0]};
  endfunction

  function automatic logic [1:0] first_ch(input logic [2:0] m);
    if (m[0])      first_ch = 2'd0;
    else if (m[1]) first_ch = 2'd1;
    else           first_ch = 2'd2;
  endfunction

  function automatic logic more_ch(input logic [2:0] m, input logic [1:0] ch);
    case (ch)
      2'd0:    more_ch = m[1] | m[2];
      2'd1:    more_ch = m[2];
      default: more_ch = 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] next_ch(input logic [2:0] m, input logic [1:0] ch);
    if (ch == 2'd0 && m[1]) next_ch = 2'd1;
    else                    next_ch = 2'd2;
  endfunction

endpackage

// File: rtl/conv_seq_mode_dec.sv
module conv_seq_mode_dec
  import conv_seq_pkg::*;
(
  input  logic [3:0] mode,
  output logic [2:0] mask,
  output logic       is_off,
  output logic       is_cont,
  output logic       is_single
);
  always_comb begin
    mask      = chan_set(mode);
    is_off    = (mask == 3'b000);
    is_cont   = !is_off && mode[3];
    is_single = !is_off && !mode[3];
  end
endmodule

// File: rtl/conv_seq_len.sv
module conv_seq_len
  import conv_seq_pkg::*;
(
  input  logic [1:0]      chan,
  input  logic [2:0]      bus_ct,
  input  logic [2:0]      shunt_ct,
  input  logic [2:0]      temp_ct,
  output logic [CT_W-1:0] len
);
  always_comb begin
    case (chan)
      2'd0:    len = ct_ticks(bus_ct);
      2'd1:    len = ct_ticks(shunt_ct) + ct_ticks(temp_ct);
      default: len = ct_ticks(temp_ct);
    endcase
  end
endmodule

// File: rtl/conv_seq_avg.sv
module conv_seq_avg
  import conv_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = DATA_W + AVG_LOG_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cap,
  input  logic [1:0]                   cap_ch,
  input  logic [DATA_W-1:0]            sample,
  input  logic                         finish,
  input  logic                         clear,
  input  logic [3:0]                   shift,
  input  logic [NCH-1:0]               mask,
  output logic [NCH-1:0][DATA_W-1:0]   res
);
  logic signed [ACC_W-1:0] sample_ext;
  assign sample_ext = {{(ACC_W-DATA_W){sample[DATA_W-1]}}, sample};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] acc_next;
    logic                    hit;

    assign hit      = cap && (cap_ch == 2'(g));
    assign acc_next = hit ? acc_q + sample_ext : acc_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q  <= '0;
        res[g] <= '0;
      end else if (clear) begin
        acc_q <= '0;
      end else if (finish) begin
        acc_q <= '0;
        if (mask[g]) res[g] <= DATA_W'(acc_next >>> shift);
      end else begin
        acc_q <= acc_next;
      end
    end
  end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int DATA_W         = 16,
  parameter int DLY_CODE_W     = 8,
  parameter int DLY_STEP_TICKS = 2000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [3:0]            cfg_mode,
  input  logic [2:0]            cfg_bus_ct,
  input  logic [2:0]            cfg_shunt_ct,
  input  logic [2:0]            cfg_temp_ct,
  input  logic [2:0]            cfg_avg,
  input  logic [DLY_CODE_W-1:0] cfg_start_dly,
  input  logic                  trig,
  input  logic                  us_tick,
  input  logic [DATA_W-1:0]     sample_in,
  output logic [2:0]            conv_req,
  output logic [DATA_W-1:0]     res_bus,
  output logic [DATA_W-1:0]     res_cur,
  output logic [DATA_W-1:0]     res_tmp,
  output logic                  done
);
  localparam int RND_W = AVG_LOG_W + 1;
  localparam int DLY_W = $clog2((2**DLY_CODE_W - 1) * DLY_STEP_TICKS + 2);

  seq_state_e        state_q, state_d;
  logic [1:0]        chan_q, chan_d;
  logic [CT_W-1:0]   cnt_q, cnt_d;
  logic [DLY_W-1:0]  dcnt_q, dcnt_d;
  logic [DLY_W-1:0]  dly_tgt_q;
  logic [RND_W-1:0]  round_q, round_d;
  logic [2:0]        mask_q;
  logic [2:0]        bus_ct_q, sh_ct_q, tmp_ct_q;
  logic [3:0]        shift_q;
  logic [2:0]        req_q;
  logic              done_q;
  logic              load_cfg, done_d;

  logic [2:0]        live_mask;
  logic              live_off, live_cont, live_single;
  logic [CT_W-1:0]   win_len;
  logic [RND_W-1:0]  rnd_last;
  logic              win_end, finish, abort;
  logic [NCH-1:0][DATA_W-1:0] res_arr;

  conv_seq_mode_dec u_dec (
    .mode      (cfg_mode),
    .mask      (live_mask),
    .is_off    (live_off),
    .is_cont   (live_cont),
    .is_single (live_single)
  );

  conv_seq_len u_len (
    .chan     (chan_q),
    .bus_ct   (bus_ct_q),
    .shunt_ct (sh_ct_q),
    .temp_ct  (tmp_ct_q),
    .len      (win_len)
  );

  assign rnd_last = (RND_W'(1) << shift_q) - RND_W'(1);
  assign win_end  = (state_q == ST_CONV) && us_tick && !live_off &&
                    (cnt_q == win_len - CT_W'(1));
  assign finish   = win_end && !more_ch(mask_q, chan_q) && (round_q == rnd_last);
  assign abort    = live_off && (state_q != ST_IDLE);

  always_comb begin
    state_d  = state_q;
    chan_d   = chan_q;
    cnt_d    = cnt_q;
    dcnt_d   = dcnt_q;
    round_d  = round_q;
    load_cfg = 1'b0;
    done_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (live_cont || (live_single && trig)) begin
          load_cfg = 1'b1;
          dcnt_d   = '0;
          state_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (live_off) begin
          state_d = ST_IDLE;
        end else if (dcnt_q == dly_tgt_q) begin
          state_d = ST_CONV;
          chan_d  = first_ch(mask_q);
          cnt_d   = '0;
          round_d = '0;
        end else if (us_tick) begin
          dcnt_d = dcnt_q + DLY_W'(1);
        end
      end
      ST_CONV: begin
        if (live_off) begin
          state_d = ST_IDLE;
        end else if (win_end) begin
          cnt_d = '0;
          if (more_ch(mask_q, chan_q)) begin
            chan_d = next_ch(mask_q, chan_q);
          end else if (!finish) begin
            chan_d  = first_ch(mask_q);
            round_d = round_q + RND_W'(1);
          end else begin
            done_d  = 1'b1;
            round_d = '0;
            if (live_cont) begin
              load_cfg = 1'b1;
              chan_d   = first_ch(live_mask);
            end else begin
              state_d = ST_IDLE;
            end
          end
        end else if (us_tick) begin
          cnt_d = cnt_q + CT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      chan_q    <= '0;
      cnt_q     <= '0;
      dcnt_q    <= '0;
      dly_tgt_q <= '0;
      round_q   <= '0;
      mask_q    <= '0;
      bus_ct_q  <= '0;
      sh_ct_q   <= '0;
      tmp_ct_q  <= '0;
      shift_q   <= '0;
      req_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
      cnt_q   <= cnt_d;
      dcnt_q  <= dcnt_d;
      round_q <= round_d;
      done_q  <= done_d;
      req_q   <= (state_d == ST_CONV) ? (3'b001 << chan_d) : 3'b000;
      if (load_cfg) begin
        mask_q    <= live_mask;
        bus_ct_q  <= cfg_bus_ct;
        sh_ct_q   <= cfg_shunt_ct;
        tmp_ct_q  <= cfg_temp_ct;
        shift_q   <= avg_log(cfg_avg);
        dly_tgt_q <= DLY_W'(cfg_start_dly) * DLY_W'(DLY_STEP_TICKS);
      end
    end
  end

  conv_seq_avg #(.DATA_W(DATA_W)) u_avg (
    .clk    (clk),
    .rst    (rst),
    .cap    (win_end),
    .cap_ch (chan_q),
    .sample (sample_in),
    .finish (finish),
    .clear  (abort),
    .shift  (shift_q),
    .mask   (mask_q),
    .res    (res_arr)
  );

  assign conv_req = req_q;
  assign done     = done_q;
  assign res_bus  = res_arr[0];
  assign res_cur  = res_arr[1];
  assign res_tmp  = res_arr[2];
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk
  import conv_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        cfg_mode,
  input logic              us_tick,
  input logic [2:0]        conv_req,
  input logic [DATA_W-1:0] res_bus,
  input logic [DATA_W-1:0] res_cur,
  input logic [DATA_W-1:0] res_tmp,
  input logic              done
);
  logic mode_off;
  assign mode_off = (chan_set(cfg_mode) == 3'b000);

  // R4
  req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(conv_req));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(res_bus) && $stable(res_cur) && $stable(res_tmp)));

  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mode_off |=> (conv_req == 3'b000) && !done);

  // R5
  req_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_req != 3'b000) && !us_tick && !mode_off |=> $stable(conv_req));
endmodule

bind conv_seq conv_seq_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/conv_seq_tb_top.sv
module conv_seq_tb_top;
  localparam int DW   = 16;
  localparam int STEP = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    cfg_mode = 4'h0;
  logic [2:0]    cfg_bus_ct = 3'd0, cfg_shunt_ct = 3'd0, cfg_temp_ct = 3'd0, cfg_avg = 3'd0;
  logic [7:0]    cfg_start_dly = 8'd0;
  logic          trig = 1'b0;
  logic          us_tick = 1'b1;
  logic [DW-1:0] sample_in = '0;
  logic [2:0]    conv_req;
  logic [DW-1:0] res_bus, res_cur, res_tmp;
  logic          done;

  always #2 clk = ~clk;

  conv_seq #(.DATA_W(DW), .DLY_CODE_W(8), .DLY_STEP_TICKS(STEP)) dut_i (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_bus_ct(cfg_bus_ct),
    .cfg_shunt_ct(cfg_shunt_ct), .cfg_temp_ct(cfg_temp_ct), .cfg_avg(cfg_avg),
    .cfg_start_dly(cfg_start_dly), .trig(trig), .us_tick(us_tick),
    .sample_in(sample_in), .conv_req(conv_req), .res_bus(res_bus),
    .res_cur(res_cur), .res_tmp(res_tmp), .done(done));

  int    n_cmp = 0, n_bad = 0, n_done = 0, n_req = 0, cyc = 0;
  bit    sparse = 1'b0, ended = 1'b0;
  string tag = "R8";
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  function automatic int ref_ticks(input int code);
    int t[8] = '{50, 84, 150, 280, 540, 1052, 2074, 4120};
    return t[code];
  endfunction

  function automatic logic [2:0] ref_set(input logic [3:0] m);
    case (m)
      4'h1, 4'h9: return 3'b001;
      4'h4, 4'hC: return 3'b100;
      4'h5, 4'hD: return 3'b101;
      4'h6, 4'hE: return 3'b110;
      4'h7, 4'hF: return 3'b111;
      default:    return 3'b000;
    endcase
  endfunction

  int          m_st = 0, m_idx = 0, m_cnt = 0, m_dcnt = 0, m_round = 0;
  int          m_nround = 1, m_shift = 0, m_tgt = 0;
  int          m_len[3];
  int          m_list[$];
  longint      m_sum[3];
  logic [DW-1:0] e_res[3];
  logic [2:0]  e_req = 3'b000;
  bit          e_done = 1'b0;
  logic [2:0]  lm;
  bit          l_off, l_cont, l_single;

  task automatic ref_load();
    int cnts[8] = '{1, 4, 16, 64, 128, 256, 512, 1024};
    m_list.delete();
    for (int c = 0; c < 3; c++) if (lm[c]) m_list.push_back(c);
    m_len[0] = ref_ticks(int'(cfg_bus_ct));
    m_len[1] = ref_ticks(int'(cfg_shunt_ct)) + ref_ticks(int'(cfg_temp_ct));
    m_len[2] = ref_ticks(int'(cfg_temp_ct));
    m_nround = cnts[cfg_avg];
    m_shift  = $clog2(m_nround);
    m_tgt    = int'(cfg_start_dly) * STEP;
    m_round  = 0; m_idx = 0; m_cnt = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; e_req = 3'b000; e_done = 1'b0;
      for (int c = 0; c < 3; c++) begin e_res[c] = '0; m_sum[c] = 0; end
    end else begin
      e_done   = 1'b0;
      lm       = ref_set(cfg_mode);
      l_off    = (lm == 3'b000);
      l_cont   = !l_off && cfg_mode >= 4'h8;
      l_single = !l_off && cfg_mode < 4'h8;
      case (m_st)
        0: if (l_cont || (l_single && trig)) begin ref_load(); m_dcnt = 0; m_st = 1; end
        1: begin
          if (l_off) m_st = 0;
          else if (m_dcnt == m_tgt) begin m_st = 2; m_idx = 0; m_cnt = 0; m_round = 0; end
          else if (us_tick) m_dcnt++;
        end
        default: begin
          if (l_off) begin
            m_st = 0;
            for (int c = 0; c < 3; c++) m_sum[c] = 0;
          end else if (us_tick) begin
            if (m_cnt == m_len[m_list[m_idx]] - 1) begin
              m_sum[m_list[m_idx]] += longint'($signed(sample_in));
              m_cnt = 0;
              if (m_idx == m_list.size() - 1) begin
                m_idx = 0;
                m_round++;
                if (m_round == m_nround) begin
                  foreach (m_list[i]) e_res[m_list[i]] = DW'(m_sum[m_list[i]] >>> m_shift);
                  for (int c = 0; c < 3; c++) m_sum[c] = 0;
                  e_done = 1'b1;
                  m_round = 0;
                  if (l_cont) ref_load(); else m_st = 0;
                end
              end else m_idx++;
            end else m_cnt++;
          end
        end
      endcase
      e_req = (m_st == 2) ? (3'b001 << m_list[m_idx]) : 3'b000;
    end
  end

  // ---------------- per-clock comparison ----------------
  always @(negedge clk) begin
    if (!ended && cyc > 1) begin
      if (rst) begin
        chk(conv_req == 3'b000 && !done, "R8", "reset req/done", {conv_req, done}, 0);
        chk(res_bus == 0 && res_cur == 0 && res_tmp == 0, "R8", "reset results",
            res_bus | res_cur | res_tmp, 0);
      end else begin
        chk(conv_req == e_req, tag, "conv_req", conv_req, e_req);
        chk(done == e_done, tag, "done", done, e_done);
        chk(res_bus == e_res[0], tag, "res_bus", res_bus, e_res[0]);
        chk(res_cur == e_res[1], tag, "res_cur", res_cur, e_res[1]);
        chk(res_tmp == e_res[2], tag, "res_tmp", res_tmp, e_res[2]);
        if (done) n_done++;
        if (conv_req != 0) n_req++;
      end
    end
  end

  // tick and sample drivers
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      us_tick   = sparse ? (cyc % 3 == 0) : 1'b1;
      lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sample_in = lfsr;
    end
  end

  task automatic pulse_trig();
    trig = 1'b1; @(negedge clk); trig = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int d0, r0;
    logic [3:0] offs[6] = '{4'h0, 4'h2, 4'h3, 4'h8, 4'hA, 4'hB};
    logic [3:0] sing[5] = '{4'h1, 4'h4, 4'h5, 4'h6, 4'h7};
    idle(6);
    rst = 1'b0;

    // R1: shutdown and reserved codes ignore the strobe
    tag = "R1";
    d0 = n_done; r0 = n_req;
    foreach (offs[i]) begin cfg_mode = offs[i]; pulse_trig(); idle(60); end
    chk(n_done == d0, "R1", "done count in off modes", n_done - d0, 0);
    chk(n_req == r0, "R1", "request cycles in off modes", n_req - r0, 0);

    // R2 R4 R5: single-shot sets, short windows
    cfg_bus_ct = 3'd0; cfg_shunt_ct = 3'd1; cfg_temp_ct = 3'd0;
    foreach (sing[i]) begin
      tag = "R2";
      cfg_mode = sing[i];
      d0 = n_done;
      pulse_trig();
      idle(400);
      chk(n_done == d0 + 1, "R2", "single-shot done count", n_done - d0, 1);
      r0 = n_req;
      idle(80);
      chk(n_req == r0, "R2", "idle after single shot", n_req - r0, 0);
    end

    // R5: thinned ticks, mixed codes
    tag = "R5";
    sparse = 1'b1; cfg_mode = 4'h7; cfg_bus_ct = 3'd1; cfg_shunt_ct = 3'd0; cfg_temp_ct = 3'd2;
    d0 = n_done;
    pulse_trig();
    idle(1500);
    chk(n_done == d0 + 1, "R5", "sparse tick run done", n_done - d0, 1);
    sparse = 1'b0;

    // R6: averaging over 4 and 16 passes
    tag = "R6";
    cfg_bus_ct = 3'd0; cfg_shunt_ct = 3'd0; cfg_temp_ct = 3'd0;
    cfg_mode = 4'h6; cfg_avg = 3'd1;
    d0 = n_done; pulse_trig(); idle(800);
    chk(n_done == d0 + 1, "R6", "avg4 done", n_done - d0, 1);
    cfg_mode = 4'h5; cfg_avg = 3'd2;
    d0 = n_done; pulse_trig(); idle(1900);
    chk(n_done == d0 + 1, "R6", "avg16 done", n_done - d0, 1);
    cfg_avg = 3'd0;

    // R7: start delay latency
    tag = "R7";
    cfg_mode = 4'h1; cfg_start_dly = 8'd3;
    trig = 1'b1;
    for (int i = 1; i <= 3 * STEP + 1; i++) begin
      @(negedge clk);
      trig = 1'b0;
      if (i == 3 * STEP + 1)
        chk(conv_req == 3'b000, "R7", "request before delay end", conv_req, 0);
    end
    @(negedge clk);
    chk(conv_req == 3'b001, "R7", "first request after delay", conv_req, 1);
    idle(120);

    // R3: continuous repeats, strobe has no effect
    tag = "R3";
    cfg_start_dly = 8'd1; cfg_mode = 4'hD;
    d0 = n_done;
    idle(500); pulse_trig(); idle(500);
    chk(n_done - d0 >= 8, "R3", "continuous pass count", n_done - d0, 8);
    cfg_mode = 4'h5;
    idle(250);
    r0 = n_req; d0 = n_done;
    idle(150);
    chk(n_req == r0 && n_done == d0, "R3", "stop after switch to single", n_req - r0, 0);

    // R9: shutdown mid-run
    tag = "R9";
    cfg_start_dly = 8'd0; cfg_mode = 4'hF;
    idle(150);
    chk(conv_req != 3'b000, "R9", "running before shutdown", conv_req, 1);
    cfg_mode = 4'h8;
    @(negedge clk);
    chk(conv_req == 3'b000, "R9", "request after shutdown", conv_req, 0);
    d0 = n_done;
    idle(300);
    chk(n_done == d0, "R9", "no done after abort", n_done - d0, 0);

    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule